// File: doc/BRIEF.md
# Serial Preamble Sequence Detector

This block watches a single serial data line and reports when a fixed 17-bit preamble has gone past. The line is sampled once per bit period. A strobe counter inside the block divides the system clock to make the sample strobe. With the default 100 MHz clock and a 0.5 µs bit, that is one sample every 50 clocks.

The data line first passes through a two-flop synchroniser. Each sample is pushed into a sliding history. When the newest 17 samples equal the preamble, the block gives a single-clock `found` pulse. Because the comparison is made over a sliding window, a broken attempt loses nothing: any tail of the received bits that is also a head of the preamble still counts toward the next match.

A controller drives `enable` high while a search is wanted. While `enable` is low, the strobe counter rests at zero and the history is emptied. Each new search therefore starts from a clean state with a known sampling phase.

Top module: `preamble_detector`

## Requirements
- R1: While synchronous reset `rst` is high, `found` and `sampleStrobe` are 0. Reset empties the bit history and returns the strobe counter to zero, so bits received before reset never complete a match.
- R2: While `enable` is high, `sampleStrobe` is high for exactly one cycle in every CLK_PER_BIT (default 50) cycles. The first strobe falls in the 50th consecutive cycle in which `enable` is high after it was low or after reset.
- R3: `serialIn` reaches the sampler through a two-flop synchroniser. A level present for 3 or more cycles before a strobe cycle is captured by that strobe. A level applied only in the cycle before the strobe is not captured.
- R4: Bits are compared in arrival order. The first-arriving bit corresponds to the most significant bit of PATTERN = 17'b10100001010000001, that is, the sequence 1,0,1,0,0,0,0,1,0,1,0,0,0,0,0,0,1. `found` is 1 in the cycle right after the strobe that captures a 17th bit completing the match.
- R5: `found` is a single-cycle pulse and is 0 in every cycle that does not directly follow a matching strobe.
- R6: No match is reported until at least 17 bits have been captured since the search began (since `enable` rose or reset was released).
- R7: A mismatch does not discard an overlapping partial match. Whenever the last 17 captured bits equal the preamble, `found` pulses, even if earlier attempts failed part way through.
- R8: The final 1 of one preamble may serve as the first 1 of the next. A second `found` pulse follows 16 further bits that complete the pattern.
- R9: While `enable` is low, `sampleStrobe` stays 0, no bits are captured and `found` stays 0.
- R10: When `enable` drops, the history is cleared. Bits received in an earlier search cannot combine with bits of a later one to form a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Search enable from the controller |
| serialIn | input | 1 | Asynchronous serial data line |
| found | output | 1 | One-cycle pulse when the preamble has matched |
| sampleStrobe | output | 1 | Bit sample strobe, brought out for debug |

## Verification
The sample strobe is combinational from the registered counter. It appears in the 50th cycle of enable and every 50 cycles after that. `found` is registered, so it is due exactly one cycle after the strobe that completes the match. The bench drives the line right after each observed strobe, which leaves 49 cycles for the 2-cycle synchroniser. It reads `found` on the cycle after every strobe and compares it with a sliding-window model of the requirements. For R3, a level is applied deliberately in the cycle just before a strobe, and the bench confirms that the strobe does not take it.

// File: rtl/preamble_pkg.sv
package preamble_pkg;

  // Control-to-datapath strobes
  typedef struct packed {
    logic sample;   // capture one line bit this cycle
    logic clear;    // search inactive: empty the history
  } ctrlStb_t;

endpackage

// File: rtl/preamble_sync.sv
module preamble_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/preamble_ctrl.sv
module preamble_ctrl
  import preamble_pkg::*;
#(
  parameter int CLK_PER_BIT = 50
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     enable,
  output ctrlStb_t stb
);
  localparam int CW = $clog2(CLK_PER_BIT);
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_BIT - 1);

  logic [CW-1:0] tickCnt;
  logic          atLast;

  assign atLast = (tickCnt == LAST);

  // Bit-period counter: held at zero while idle so each search starts in phase
  always_ff @(posedge clk) begin
    if (rst || !enable)  tickCnt <= '0;
    else if (atLast)     tickCnt <= '0;
    else                 tickCnt <= tickCnt + 1'b1;
  end

  always_comb begin
    stb.sample = enable && atLast && !rst;
    stb.clear  = !enable;
  end

  AST_CNT_IN_RANGE:  assert property (@(posedge clk) disable iff (rst) tickCnt <= LAST); // R2
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst) stb.sample |=> !stb.sample); // R2
  AST_IDLE_RESTS:    assert property (@(posedge clk) disable iff (rst) !enable |=> (tickCnt == '0)); // R9
endmodule

// File: rtl/preamble_dp.sv
module preamble_dp
  import preamble_pkg::*;
#(
  parameter int             LEN         = 17,
  parameter logic [LEN-1:0] PATTERN     = 17'b10100001010000001,
  parameter int             SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  ctrlStb_t stb,
  input  logic     serialIn,
  output logic     found
);
  localparam int FW = $clog2(LEN + 1);
  localparam logic [FW-1:0] FULL = FW'(LEN);

  logic           lineBit;
  logic [LEN-2:0] hist;
  logic [LEN-1:0] window;
  logic [FW-1:0]  bitsSeen;
  logic           fullNext;

  preamble_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (serialIn),
    .q   (lineBit)
  );

  // Newest bit at LSB: oldest of the window lands on the MSB
  assign window   = {hist, lineBit};
  assign fullNext = (bitsSeen >= FULL - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || stb.clear) begin
      hist     <= '0;
      bitsSeen <= '0;
      found    <= 1'b0;
    end else if (stb.sample) begin
      hist     <= window[LEN-2:0];
      if (bitsSeen != FULL) bitsSeen <= bitsSeen + 1'b1;
      found    <= fullNext && (window == PATTERN);
    end else begin
      found    <= 1'b0;
    end
  end

  AST_FOUND_PULSE:  assert property (@(posedge clk) disable iff (rst) found |=> !found); // R5
  AST_FOUND_ON_STB: assert property (@(posedge clk) disable iff (rst) found |-> $past(stb.sample)); // R4
  AST_FILL_LIMIT:   assert property (@(posedge clk) disable iff (rst) bitsSeen <= FULL); // R6
  AST_CLEAR_EMPTY:  assert property (@(posedge clk) disable iff (rst) stb.clear |=> (bitsSeen == '0 && !found)); // R10
endmodule

// File: rtl/preamble_detector.sv
module preamble_detector
  import preamble_pkg::*;
#(
  parameter int             CLK_PER_BIT = 50,
  parameter int             LEN         = 17,
  parameter logic [LEN-1:0] PATTERN     = 17'b10100001010000001
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic serialIn,
  output logic found,
  output logic sampleStrobe
);
  ctrlStb_t stb;

  preamble_ctrl #(.CLK_PER_BIT(CLK_PER_BIT)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .enable (enable),
    .stb    (stb)
  );

  preamble_dp #(.LEN(LEN), .PATTERN(PATTERN), .SYNC_STAGES(2)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .serialIn (serialIn),
    .found    (found)
  );

  assign sampleStrobe = stb.sample;

  AST_RESET_QUIET: assert property (@(posedge clk) rst |-> !sampleStrobe); // R1
endmodule

// File: tb/preamble_detector_test.sv
module preamble_detector_test;
  localparam logic [16:0] PAT = 17'b10100001010000001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic serialIn = 1'b0;
  logic found, sampleStrobe;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [16:0] mHist = '0;
  int          mSeen = 0;

  preamble_detector uut (
    .clk(clk), .rst(rst), .enable(enable), .serialIn(serialIn),
    .found(found), .sampleStrobe(sampleStrobe)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic waitStrobe(output int n);
    n = 0;
    while (!sampleStrobe && n < 400) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic beginSearch();
    enable = 1'b1;
    mHist = '0;
    mSeen = 0;
  endtask

  task automatic endSearch();
    enable = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Drive one bit, wait for its strobe, check found in the following cycle
  task automatic sendBit(input logic b, input string req);
    int n;
    serialIn = b;
    waitStrobe(n);
    @(negedge clk);
    mHist = {mHist[15:0], b};
    if (mSeen < 17) mSeen++;
    chk(req, int'(found), int'(mSeen >= 17 && mHist == PAT));
  endtask

  task automatic sendPattern(input int firstIdx, input string req);
    for (int i = firstIdx; i < 17; i++) sendBit(PAT[16-i], req);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 found in reset", int'(found), 0);
    chk("R1 strobe in reset", int'(sampleStrobe), 0);
    enable = 1'b1;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (sampleStrobe) begin chk("R1 strobe held by reset", 1, 0); break; end
    end
    enable = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk("R1 found after reset", int'(found), 0);
  endtask

  task automatic t_strobe();
    int n;
    beginSearch();
    waitStrobe(n);
    chk("R2 first strobe edges", n, 49);
    @(negedge clk);
    chk("R2 strobe width", int'(sampleStrobe), 0);
    waitStrobe(n);
    chk("R2 strobe period", n + 1, 50);
    @(negedge clk);
    waitStrobe(n);
    chk("R2 strobe period again", n + 1, 50);
    endSearch();
  endtask

  task automatic t_clean();
    serialIn = 1'b1;
    beginSearch();
    sendPattern(0, "R4 R6 clean preamble");
    chk("R4 match seen", int'(mHist == PAT), 1);
    @(negedge clk);
    chk("R5 found single cycle", int'(found), 0);
    endSearch();
  endtask

  task automatic t_overlap();
    logic [12:0] lead1 = 13'b1010000101001;
    logic [16:0] lead0 = 17'b10100001010000000;
    serialIn = 1'b1;
    beginSearch();
    for (int i = 12; i >= 0; i--) sendBit(lead1[i], "R7 broken by one");
    sendPattern(0, "R7 restart after 1");
    for (int i = 16; i >= 0; i--) sendBit(lead0[i], "R7 broken by zero");
    sendPattern(0, "R7 restart after 0");
    endSearch();
  endtask

  task automatic t_backToBack();
    serialIn = 1'b1;
    beginSearch();
    sendPattern(0, "R8 first preamble");
    sendPattern(1, "R8 shared final one");
    chk("R8 second match", int'(found), 1);
    endSearch();
  endtask

  task automatic t_enableDrop();
    serialIn = 1'b1;
    beginSearch();
    for (int i = 0; i < 16; i++) sendBit(PAT[16-i], "R10 prefix");
    enable = 1'b0;
    for (int i = 0; i < 120; i++) begin
      serialIn = i[0];
      @(negedge clk);
      if (sampleStrobe || found) begin chk("R9 idle activity", 1, 0); break; end
    end
    chk("R9 idle quiet", int'(sampleStrobe | found), 0);
    beginSearch();
    sendBit(1'b1, "R10 stale prefix no match");
    chk("R10 no match from stale bits", int'(found), 0);
    sendPattern(1, "R10 fresh search");
    endSearch();
  endtask

  task automatic t_resetMid();
    serialIn = 1'b1;
    beginSearch();
    for (int i = 0; i < 16; i++) sendBit(PAT[16-i], "R1 prefix");
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mHist = '0;
    mSeen = 0;
    sendBit(1'b1, "R1 no match across reset");
    chk("R1 reset clears history", int'(found), 0);
    endSearch();
  endtask

  task automatic t_lateEdge();
    serialIn = 1'b1;
    beginSearch();
    for (int i = 0; i < 16; i++) sendBit(PAT[16-i], "R3 prefix");
    serialIn = 1'b0;
    repeat (48) @(negedge clk);
    serialIn = 1'b1;
    @(negedge clk);
    chk("R3 strobe at expected cycle", int'(sampleStrobe), 1);
    @(negedge clk);
    chk("R3 late level not captured", int'(found), 0);
    mHist = {mHist[15:0], 1'b0};
    endSearch();
  endtask

  initial begin
    t_reset();
    t_strobe();
    t_clean();
    t_overlap();
    t_backToBack();
    t_enableDrop();
    t_resetMid();
    t_lateEdge();
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end
endmodule